// File: doc/BRIEF.md
# SDRAM Clock-Enable State Tracker

This block follows the clock-enable behaviour of a single-data-rate SDRAM. It is meant for a controller or a checker that must know, edge by edge, what the memory will do with the command lines. On every rising clock edge it registers CKE and keeps the value from the edge before. It decodes the chip-select, row-strobe, column-strobe and write-enable lines into a command class. From the pair of CKE samples, the command and the current state, it moves between idle, read/write, power-down, self refresh, clock suspend and a self-refresh recovery state.

The recovery state counts a parameterised number of cycles, `XSR_CYC`. It also requires at least `MIN_NOPS` no-operation commands before it reports idle again. The tracker drives a flag that tells whether a command presented on the next edge will be accepted. Any combination that the rules do not allow sets a sticky error output and leaves the state where it was.

Top module: `cke_state_tracker`

## Requirements
- R1: While `rst_n` is low and after it is released, `state_o` is 0 (idle), `cmd_ready` is 0, `illegal_err` is 0, and the registered previous CKE is low.
- R2: State codes on `state_o`: 0 idle, 1 read/write, 2 power-down, 3 self refresh, 4 clock suspend, 5 self-refresh recovery. When CKE is high at both edges, idle moves to read/write on READ (`{cs_n,ras_n,cas_n,we_n}` = 0101) or WRITE (0100). Read/write moves to idle on PRECHARGE (0010). Every other command holds the state.
- R3: In idle, CKE high then low with NOP (0111) or inhibit (`cs_n` = 1) enters power-down.
- R4: In idle, CKE high then low with AUTO REFRESH (0001) enters self refresh.
- R5: In read/write, CKE high then low with any command enters clock suspend.
- R6: In power-down, self refresh or clock suspend, CKE low at both edges holds the state, whatever the command.
- R7: In power-down, CKE low then high with NOP or inhibit returns to idle after that edge, and `cmd_ready` is high before the next edge.
- R8: In self refresh, CKE low then high with NOP or inhibit enters recovery. The tracker then spends `XSR_CYC` edges in recovery and reports idle after the last of them, provided CKE stayed high and every one of those edges carried NOP or inhibit.
- R9: During recovery, an edge without CKE high at both samples, or with a command other than NOP or inhibit, is illegal. Idle is reported only on a legal NOP edge once `XSR_CYC` edges have passed and at least `MIN_NOPS` legal NOP edges have been seen in recovery.
- R10: In clock suspend, CKE low then high with any command returns to read/write.
- R11: Any combination not named in R2 to R10 or R13 sets `illegal_err`, which stays set until reset. The state is held on that edge.
- R12: `cmd_ready` is high exactly when the state is idle or read/write and CKE was high at the most recent edge.
- R13: In idle or read/write, an edge whose previous CKE sample is low ignores the command, holds the state and raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable sampled at each edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| state_o | output | 3 | Current tracked state (codes in R2) |
| cmd_ready | output | 1 | A command on the next edge will be accepted |
| illegal_err | output | 1 | Sticky flag for an illegal combination |

## Verification
Some properties are checked on every cycle. The error flag never clears on its own. An illegal edge leaves the state unchanged. Low-power states hold while CKE stays low. Read/write always falls into clock suspend on a CKE drop, and clock suspend always returns to it. Recovery can only be entered from self refresh. A legal power-down exit always raises the ready flag. The recovery counter never reaches zero while it runs.

Other behaviour only shows across a sequence, so the bench scenarios carry it. This covers the exact length of the recovery window, idle being delayed when too few NOPs arrive, the commands ignored right after reset, and the ready flag after every kind of exit.

// File: rtl/cke_trk_pkg.sv
package cke_trk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RW   = 3'd1,
      ST_PDN  = 3'd2,
      ST_SREF = 3'd3,
      ST_CSUS = 3'd4,
      ST_SRX  = 3'd5
   } trk_state_t;

   typedef enum logic [2:0] {
      C_NOP   = 3'd0,
      C_AREF  = 3'd1,
      C_RDWR  = 3'd2,
      C_PRE   = 3'd3,
      C_OTHER = 3'd4
   } trk_cmd_t;

endpackage

// File: rtl/cke_cmd_decode.sv
module cke_cmd_decode
   import cke_trk_pkg::*;
(
   input  logic     cs_n,
   input  logic     ras_n,
   input  logic     cas_n,
   input  logic     we_n,
   output trk_cmd_t cmd
);

   always_comb begin
      if (cs_n) begin
         cmd = C_NOP;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b111:         cmd = C_NOP;
            3'b001:         cmd = C_AREF;
            3'b101, 3'b100: cmd = C_RDWR;
            3'b010:         cmd = C_PRE;
            default:        cmd = C_OTHER;
         endcase
      end
   end

endmodule

// File: rtl/cke_xsr_timer.sv
module cke_xsr_timer #(
   parameter int XSR_CYC  = 8,
   parameter int MIN_NOPS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   input  logic nop_in,
   output logic done
);

   localparam int CW = $clog2(XSR_CYC + 1);

   logic [CW-1:0] cnt;
   logic          enough;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= CW'(XSR_CYC);
      end else if (load) begin
         cnt <= CW'(XSR_CYC);
      end else if (run && cnt > CW'(1)) begin
         cnt <= cnt - CW'(1);
      end
   end

   generate
      if (MIN_NOPS > 0) begin : g_nop_count
         localparam int NW = $clog2(MIN_NOPS + 1);
         logic [NW-1:0] nops;
         always_ff @(posedge clk) begin
            if (!rst_n || load) begin
               nops <= '0;
            end else if (run && nop_in && nops < NW'(MIN_NOPS)) begin
               nops <= nops + NW'(1);
            end
         end
         assign enough = (int'(nops) + int'(nop_in)) >= MIN_NOPS;
      end else begin : g_no_nop_count
         assign enough = 1'b1;
      end
   endgenerate

   assign done = run && (cnt == CW'(1)) && enough;

   a_r8_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt != '0))
      else $error("recovery counter at zero while running");

endmodule

// File: rtl/cke_state_tracker.sv
module cke_state_tracker
   import cke_trk_pkg::*;
#(
   parameter int XSR_CYC  = 8,
   parameter int MIN_NOPS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cke,
   input  logic       cs_n,
   input  logic       ras_n,
   input  logic       cas_n,
   input  logic       we_n,
   output logic [2:0] state_o,
   output logic       cmd_ready,
   output logic       illegal_err
);

   generate
      if (XSR_CYC < 2) begin : g_bad_xsr
         $error("XSR_CYC must be at least 2");
      end
      if (MIN_NOPS > XSR_CYC) begin : g_bad_nops
         $error("MIN_NOPS cannot exceed XSR_CYC");
      end
   endgenerate

   trk_cmd_t   cmd;
   trk_state_t st, nxt;
   logic       ck_q, bad, start, run, nop_ok, done;

   cke_cmd_decode u_dec (
      .cs_n (cs_n),
      .ras_n(ras_n),
      .cas_n(cas_n),
      .we_n (we_n),
      .cmd  (cmd)
   );

   assign run    = (st == ST_SRX);
   assign nop_ok = run && ck_q && cke && (cmd == C_NOP);

   cke_xsr_timer #(
      .XSR_CYC (XSR_CYC),
      .MIN_NOPS(MIN_NOPS)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .run   (run),
      .nop_in(nop_ok),
      .done  (done)
   );

   always_comb begin
      nxt   = st;
      bad   = 1'b0;
      start = 1'b0;
      unique case (st)
         ST_IDLE: if (ck_q) begin
            if (cke) begin
               if (cmd == C_RDWR) nxt = ST_RW;
            end else if (cmd == C_NOP) begin
               nxt = ST_PDN;
            end else if (cmd == C_AREF) begin
               nxt = ST_SREF;
            end else begin
               bad = 1'b1;
            end
         end
         ST_RW: if (ck_q) begin
            if (cke) begin
               if (cmd == C_PRE) nxt = ST_IDLE;
            end else begin
               nxt = ST_CSUS;
            end
         end
         ST_PDN: begin
            if (ck_q) bad = 1'b1;
            else if (cke) begin
               if (cmd == C_NOP) nxt = ST_IDLE;
               else bad = 1'b1;
            end
         end
         ST_SREF: begin
            if (ck_q) bad = 1'b1;
            else if (cke) begin
               if (cmd == C_NOP) begin
                  nxt   = ST_SRX;
                  start = 1'b1;
               end else begin
                  bad = 1'b1;
               end
            end
         end
         ST_CSUS: begin
            if (ck_q) bad = 1'b1;
            else if (cke) nxt = ST_RW;
         end
         ST_SRX: begin
            if (nop_ok) begin
               if (done) nxt = ST_IDLE;
            end else begin
               bad = 1'b1;
            end
         end
         default: begin
            nxt = ST_IDLE;
            bad = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         ck_q        <= 1'b0;
         illegal_err <= 1'b0;
      end else begin
         st   <= nxt;
         ck_q <= cke;
         if (bad) illegal_err <= 1'b1;
      end
   end

   assign state_o   = st;
   assign cmd_ready = ((st == ST_IDLE) || (st == ST_RW)) && ck_q;

   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_err |=> illegal_err)
      else $error("error flag cleared");

   a_r11_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(illegal_err) |-> $stable(state_o))
      else $error("state moved on an illegal edge");

   a_r6_lp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_PDN || st == ST_SREF || st == ST_CSUS) && !ck_q && !cke)
      |=> $stable(state_o))
      else $error("low-power state not held");

   a_r5_suspend_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RW && ck_q && !cke) |=> (state_o == 3'd4))
      else $error("clock suspend not entered");

   a_r10_suspend_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CSUS && !ck_q && cke) |=> (state_o == 3'd1))
      else $error("clock suspend not left");

   a_r7_pdn_exit_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PDN && !ck_q && cke && cmd == C_NOP) |=> cmd_ready)
      else $error("not ready after power-down exit");

   a_r8_srx_from_sref: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_o == 3'd5) |-> ($past(state_o) == 3'd3))
      else $error("recovery entered from a state other than self refresh");

endmodule

// File: tb/cke_state_tracker_bench.sv
`timescale 1ns/1ps
module cke_state_tracker_bench;

   localparam int XSR  = 5;
   localparam int MINN = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cke = 1'b0;
   logic [3:0] c = 4'b0111;
   logic [2:0] state_o;
   logic       cmd_ready, illegal_err;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   int   m_st, m_cnt, m_nops;
   logic m_ckq, m_err;

   always #2.5 clk = ~clk;

   cke_state_tracker #(.XSR_CYC(XSR), .MIN_NOPS(MINN)) u_cke_state_tracker (
      .clk(clk), .rst_n(rst_n), .cke(cke),
      .cs_n(c[3]), .ras_n(c[2]), .cas_n(c[1]), .we_n(c[0]),
      .state_o(state_o), .cmd_ready(cmd_ready), .illegal_err(illegal_err)
   );

   localparam logic [3:0] NOP = 4'b0111, INH = 4'b1010, AREF = 4'b0001,
                          RD = 4'b0101, WR = 4'b0100, PRE = 4'b0010,
                          ACT = 4'b0011, MRS = 4'b0000;

   // 0 nop/inhibit, 1 auto refresh, 2 read/write, 3 precharge, 4 other
   function automatic int cls(input logic [3:0] x);
      if (x[3]) return 0;
      case (x[2:0])
         3'b111: return 0;
         3'b001: return 1;
         3'b101, 3'b100: return 2;
         3'b010: return 3;
         default: return 4;
      endcase
   endfunction

   function automatic logic exp_ready();
      return (m_st == 0 || m_st == 1) && m_ckq;
   endfunction

   task automatic model_step(input logic ck, input logic [3:0] x, output string tag);
      int k = cls(x);
      int ns = m_st;
      logic bad = 1'b0;
      tag = "R11";
      case (m_st)
         0: if (!m_ckq) tag = "R13";
            else if (ck) begin if (k == 2) ns = 1; tag = "R2"; end
            else if (k == 0) begin ns = 2; tag = "R3"; end
            else if (k == 1) begin ns = 3; tag = "R4"; end
            else bad = 1'b1;
         1: if (!m_ckq) tag = "R13";
            else if (ck) begin if (k == 3) ns = 0; tag = "R2"; end
            else begin ns = 4; tag = "R5"; end
         2: if (!m_ckq && !ck) tag = "R6";
            else if (!m_ckq && k == 0) begin ns = 0; tag = "R7"; end
            else bad = 1'b1;
         3: if (!m_ckq && !ck) tag = "R6";
            else if (!m_ckq && k == 0) begin
               ns = 5; m_cnt = XSR; m_nops = 0; tag = "R8";
            end else bad = 1'b1;
         4: if (!m_ckq && !ck) tag = "R6";
            else if (!m_ckq) begin ns = 1; tag = "R10"; end
            else bad = 1'b1;
         default: begin
            logic okn = m_ckq && ck && (k == 0);
            tag = "R8";
            if (okn) begin
               if (m_cnt == 1 && (m_nops + 1) >= MINN) ns = 0;
               else if (m_cnt == 1) tag = "R9";
            end else begin
               bad = 1'b1;
               tag = "R9";
            end
            if (okn && m_nops < MINN) m_nops++;
            if (m_cnt > 1) m_cnt--;
         end
      endcase
      if (bad) m_err = 1'b1;
      m_st  = ns;
      m_ckq = ck;
   endtask

   task automatic compare(input string tag);
      n_chk++;
      if (state_o !== 3'(m_st) || cmd_ready !== exp_ready() || illegal_err !== m_err) begin
         n_fail++;
         $display("FAIL %s (ready R12): state %0d/%0d ready %0b/%0b err %0b/%0b (actual/expected)",
                  tag, state_o, m_st, cmd_ready, exp_ready(), illegal_err, m_err);
      end
   endtask

   // called at a falling edge; returns at a falling edge
   task automatic do_reset();
      rst_n = 1'b0; cke = 1'b0; c = NOP;
      m_st = 0; m_ckq = 1'b0; m_err = 1'b0; m_cnt = XSR; m_nops = 0;
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
   endtask

   task automatic step(input logic ck, input logic [3:0] x);
      string tag;
      cke = ck; c = x;
      model_step(ck, x, tag);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R1: run did not complete");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      @(negedge clk);
      do_reset();
      // R13: first edge after reset with prior CKE low, READ ignored
      step(1, RD);
      // R2: read enters read/write, precharge returns
      step(1, RD); step(1, ACT); step(1, PRE); step(1, WR); step(1, PRE);
      // R3, R6, R7: power-down with junk commands, exit with inhibit
      step(0, NOP); step(0, RD); step(0, MRS); step(1, INH); step(1, NOP);
      // R4, R6, R8: self refresh, exact recovery window
      step(0, AREF); step(0, ACT); step(1, NOP);
      for (int i = 0; i < XSR; i++) step(1, (i % 2) ? INH : NOP);
      step(1, RD);
      // R5, R10: clock suspend and return
      step(0, WR); step(0, PRE); step(1, AREF); step(1, PRE);
      // R11: illegal fall from idle with READ
      step(0, RD); step(1, NOP);
      // R9: recovery with too few NOPs delays idle
      do_reset();
      step(1, NOP); step(0, AREF); step(1, NOP);
      for (int i = 0; i < XSR - 1; i++) step(1, RD);
      step(1, NOP); step(1, NOP); step(1, NOP);
      // R9: CKE drop during recovery
      do_reset();
      step(1, NOP); step(0, AREF); step(1, NOP); step(0, NOP);
      step(1, NOP); for (int i = 0; i < XSR + 2; i++) step(1, NOP);
      // constrained random segments
      for (int s = 0; s < 20; s++) begin
         logic ck = 1'b1;
         do_reset();
         for (int i = 0; i < 150; i++) begin
            int r = int'($urandom_range(0, 99));
            logic [3:0] x;
            if ($urandom_range(0, 99) < 25) ck = ~ck;
            if (r < 45)      x = NOP;
            else if (r < 55) x = INH;
            else if (r < 65) x = AREF;
            else if (r < 75) x = RD;
            else if (r < 82) x = WR;
            else if (r < 92) x = PRE;
            else             x = ($urandom_range(0, 1) != 0) ? ACT : MRS;
            step(ck, x);
         end
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule